// File: doc/BRIEF.md
# Shared PWM Waveform Generator Bank

This block drives a large set of slow on/off output pins from a small pool of shared waveform generators. Eight generators each run a repeating period measured in coarse ticks, and each is high for a fraction of that period set by an 8-bit duty value. Pins own no counters. Each pin has a 4-bit map entry that enables it and names the generator whose waveform it copies. Sixteen pins drive outputs directly. Seventeen more form a parallel state vector for a serial path, and the shifting itself is done elsewhere.

Software sets generator timing and the pin map through a simple 32-bit register write port. A prescaler divides the system clock into sub-ticks, and 255 sub-ticks make one coarse tick. With `SUBTICK_DIV` set to the right value for the system clock, a coarse tick is 4 ms. A generator's new settings never cut its running period short. It loads them only when that period ends, so that outputs do not glitch when software changes them.

Top module: `pwm_gen_bank`

## Requirements
- R1: While `rst_n` is low and right after reset, every pin output is low and every generator is stopped, holding a period of 0.
- R2: A sub-tick occurs once every `SUBTICK_DIV` clocks. One coarse tick is 255 sub-ticks. A generator with period P (1..250) repeats every P*255*`SUBTICK_DIV` clocks.
- R3: The output is non-inverted. For a running generator with period P and duty D, each period starts high for the first D*P sub-ticks and is low for the rest. That is D/255 of the period.
- R4: A duty of 255 keeps the generator high for the whole period. A duty of 0 keeps it low for the whole period.
- R5: A period of 0 stops the generator and keeps its output low. A stopped generator loads its configured settings at every sub-tick, so it restarts with a high phase at the next sub-tick after a non-zero period is written.
- R6: A write to a generator's period or duty during a running period does not change that period. The period completes with the old values, and the new values take effect from the next period boundary.
- R7: Word addresses 0..3 hold generator parameters. Word k holds the duty of generator 2k in bits 7:0 and the duty of generator 2k+1 in bits 23:16. Bits 15:8 and 31:24 carry the low portion fields, which are accepted and have no effect on any output.
- R8: Word addresses 4 and 5 hold periods. Generator 4k+j takes bits 8j+7:8j of word 4+k.
- R9: Each pin's 4-bit map entry uses bit 3 as the enable and bits 2:0 as the generator index. Direct pin p is set at word 6 + p/8, bits 4*(p%8)+3 : 4*(p%8). Serial pin s is set at word 8 + s/8, using the same nibble position.
- R10: A disabled pin drives a constant low. An enabled pin follows its selected generator. Any number of pins may share one generator and show the same waveform.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one word per cycle |
| wr_addr | input | 4 | Word address of the write |
| wr_data | input | 32 | Write data |
| direct_pin | output | 16 | Directly driven pin outputs |
| serial_pin | output | 17 | Pin states handed to the serial output path |

## Verification
The bench targets the following corner cases. Each is listed with the failure it would expose.

- **Mid-period reprogramming.** A generator is switched from full duty to zero duty just after its period starts. A design that loads settings at once would drop the pin low well before the period boundary.
- **Stopping and restarting.** A period of 0 stops a generator. A design that kept counting after the stop would leave the pin toggling. A design that waited for a stale boundary before restarting would not show the high phase within a few clocks.
- **Field placement.** The ignored low-portion bytes are filled with non-zero patterns, and generators 4 and up are placed in the second period word. A slipped bit position would then show as a wrong high count.
- **Pin map.** Disabled pins point at a generator that is high, and the last serial pin sits alone in its word. A decode error at either boundary would show up as a wrong pin level.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

  localparam int FIELD_W   = 8;
  localparam int MAP_W     = 4;
  localparam int CNT_W     = 16;
  localparam int DUTY_FULL = 255;

  // sub-ticks in one period of `per` coarse ticks
  function automatic logic [CNT_W-1:0] period_subticks(input logic [FIELD_W-1:0] per);
    return {8'b0, per} * CNT_W'(DUTY_FULL);
  endfunction

  // sub-ticks spent high: duty/255 of the period, exact at sub-tick resolution
  function automatic logic [CNT_W-1:0] high_subticks(input logic [FIELD_W-1:0] duty,
                                                     input logic [FIELD_W-1:0] per);
    return {8'b0, duty} * {8'b0, per};
  endfunction

endpackage

// File: rtl/pwm_subtick_prescaler.sv
module pwm_subtick_prescaler #(
  parameter int DIV = 784
) (
  input  logic clk,
  input  logic rst_n,
  output logic sub_tick
);

  generate
    if (DIV <= 1) begin : g_pass
      assign sub_tick = 1'b1;
    end else begin : g_div
      localparam int CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
      end

      assign sub_tick = (cnt == LAST);
    end
  endgenerate

endmodule

// File: rtl/pwm_wavegen.sv
module pwm_wavegen
  import pwm_bank_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sub_tick,
  input  logic [FIELD_W-1:0] cfg_per,
  input  logic [FIELD_W-1:0] cfg_duty,
  output logic               wave,
  output logic               period_end,
  output logic [FIELD_W-1:0] act_per,
  output logic [FIELD_W-1:0] act_duty
);

  logic [CNT_W-1:0] cnt;

  // a stopped generator counts as "at a boundary" so it picks up settings at once
  assign period_end = (act_per == '0) ||
                      (cnt == period_subticks(act_per) - CNT_W'(1));
  assign wave       = (act_per != '0) && (cnt < high_subticks(act_duty, act_per));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      act_per  <= '0;
      act_duty <= '0;
    end else if (sub_tick) begin
      if (period_end) begin
        cnt      <= '0;
        act_per  <= cfg_per;
        act_duty <= cfg_duty;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/pwm_pin_mux.sv
module pwm_pin_mux #(
  parameter int NUM_GEN  = 8,
  parameter int NUM_PINS = 33
) (
  input  logic [NUM_GEN-1:0]       gen_wave,
  input  logic [NUM_PINS-1:0][3:0] pin_map,
  output logic [NUM_PINS-1:0]      pin_out
);

  generate
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      assign pin_out[p] = pin_map[p][3] & gen_wave[pin_map[p][2:0]];
    end
  endgenerate

endmodule

// File: rtl/pwm_gen_bank.sv
module pwm_gen_bank
  import pwm_bank_pkg::*;
#(
  parameter int NUM_GEN     = 8,
  parameter int NUM_DIRECT  = 16,
  parameter int NUM_SERIAL  = 17,
  parameter int ADDR_W      = 4,
  parameter int SUBTICK_DIV = 784
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [31:0]           wr_data,
  output logic [NUM_DIRECT-1:0] direct_pin,
  output logic [NUM_SERIAL-1:0] serial_pin
);

  localparam int NUM_PINS   = NUM_DIRECT + NUM_SERIAL;
  localparam int DUTY_BASE  = 0;
  localparam int DUTY_WORDS = (NUM_GEN + 1) / 2;
  localparam int PER_BASE   = DUTY_BASE + DUTY_WORDS;
  localparam int PER_WORDS  = (NUM_GEN + 3) / 4;
  localparam int DMAP_BASE  = PER_BASE + PER_WORDS;
  localparam int DMAP_WORDS = (NUM_DIRECT + 7) / 8;
  localparam int SMAP_BASE  = DMAP_BASE + DMAP_WORDS;

  logic [NUM_GEN-1:0][FIELD_W-1:0] duty_cfg;
  logic [NUM_GEN-1:0][FIELD_W-1:0] per_cfg;
  logic [NUM_PINS-1:0][MAP_W-1:0]  pin_map;

  // named internal events for the checker
  logic                            sub_tick;
  logic [NUM_GEN-1:0]              gen_wave;
  logic [NUM_GEN-1:0]              gen_last;
  logic [NUM_GEN-1:0][FIELD_W-1:0] act_per;
  logic [NUM_GEN-1:0][FIELD_W-1:0] act_duty;
  logic [NUM_PINS-1:0]             pin_all;

  // configuration write decode
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_cfg <= '0;
      per_cfg  <= '0;
      pin_map  <= '0;
    end else if (wr_en) begin
      for (int g = 0; g < NUM_GEN; g++) begin
        if (wr_addr == ADDR_W'(DUTY_BASE + g / 2))
          duty_cfg[g] <= wr_data[16 * (g % 2) +: FIELD_W];
        if (wr_addr == ADDR_W'(PER_BASE + g / 4))
          per_cfg[g] <= wr_data[8 * (g % 4) +: FIELD_W];
      end
      for (int p = 0; p < NUM_DIRECT; p++) begin
        if (wr_addr == ADDR_W'(DMAP_BASE + p / 8))
          pin_map[p] <= wr_data[4 * (p % 8) +: MAP_W];
      end
      for (int s = 0; s < NUM_SERIAL; s++) begin
        if (wr_addr == ADDR_W'(SMAP_BASE + s / 8))
          pin_map[NUM_DIRECT + s] <= wr_data[4 * (s % 8) +: MAP_W];
      end
    end
  end

  pwm_subtick_prescaler #(.DIV(SUBTICK_DIV)) u_presc (
    .clk      (clk),
    .rst_n    (rst_n),
    .sub_tick (sub_tick)
  );

  generate
    for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
      pwm_wavegen u_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .sub_tick   (sub_tick),
        .cfg_per    (per_cfg[g]),
        .cfg_duty   (duty_cfg[g]),
        .wave       (gen_wave[g]),
        .period_end (gen_last[g]),
        .act_per    (act_per[g]),
        .act_duty   (act_duty[g])
      );
    end
  endgenerate

  pwm_pin_mux #(.NUM_GEN(NUM_GEN), .NUM_PINS(NUM_PINS)) u_mux (
    .gen_wave (gen_wave),
    .pin_map  (pin_map),
    .pin_out  (pin_all)
  );

  assign direct_pin = pin_all[NUM_DIRECT-1:0];
  assign serial_pin = pin_all[NUM_PINS-1:NUM_DIRECT];

endmodule

// File: rtl/pwm_gen_bank_chk.sv
module pwm_gen_bank_chk #(
  parameter int NUM_GEN     = 8,
  parameter int NUM_PINS    = 33,
  parameter int SUBTICK_DIV = 784
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      sub_tick,
  input logic [NUM_GEN-1:0]        gen_wave,
  input logic [NUM_GEN-1:0]        gen_last,
  input logic [NUM_GEN-1:0][7:0]   act_per,
  input logic [NUM_GEN-1:0][7:0]   act_duty,
  input logic [NUM_PINS-1:0][3:0]  pin_map,
  input logic [NUM_PINS-1:0]       pin_all
);

  generate
    if (SUBTICK_DIV > 1) begin : g_spacing
      AST_SUBTICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        sub_tick |=> !sub_tick); // R2
    end

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
      AST_HOLD_MIDPERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        !(sub_tick && gen_last[g]) |=> $stable(act_per[g]) && $stable(act_duty[g])); // R6
      AST_STOPPED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (act_per[g] == 8'd0) |-> !gen_wave[g]); // R5
      AST_FULL_DUTY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (act_per[g] != 8'd0 && act_duty[g] == 8'd255) |-> gen_wave[g]); // R4
      AST_ZERO_DUTY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (act_duty[g] == 8'd0) |-> !gen_wave[g]); // R4
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      AST_DISABLED_PIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_map[p][3] |-> !pin_all[p]); // R10
    end
  endgenerate

endmodule

bind pwm_gen_bank pwm_gen_bank_chk #(
  .NUM_GEN     (NUM_GEN),
  .NUM_PINS    (NUM_PINS),
  .SUBTICK_DIV (SUBTICK_DIV)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sub_tick (sub_tick),
  .gen_wave (gen_wave),
  .gen_last (gen_last),
  .act_per  (act_per),
  .act_duty (act_duty),
  .pin_map  (pin_map),
  .pin_all  (pin_all)
);

// File: tb/pwm_gen_bank_tb.sv
module pwm_gen_bank_tb;

  localparam int DIV = 2;
  localparam int NP  = 33;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [15:0] direct_pin;
  logic [16:0] serial_pin;
  logic [32:0] allp;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  assign allp = {serial_pin, direct_pin};

  always #10 clk = ~clk;

  pwm_gen_bank #(.SUBTICK_DIV(DIV)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .direct_pin (direct_pin),
    .serial_pin (serial_pin)
  );

  // ---------------- behavioural reference model ----------------
  int pre;
  int m_cnt[8], m_per[8], m_duty[8];
  int c_per[8], c_duty[8];
  int c_map[NP];

  always @(posedge clk) begin
    if (!rst_n) begin
      pre = 0;
      for (int g = 0; g < 8; g++) begin
        m_cnt[g] = 0; m_per[g] = 0; m_duty[g] = 0; c_per[g] = 0; c_duty[g] = 0;
      end
      for (int p = 0; p < NP; p++) c_map[p] = 0;
    end else begin
      bit st;
      st  = (pre == DIV - 1);
      pre = st ? 0 : pre + 1;
      if (st) begin
        for (int g = 0; g < 8; g++) begin
          if (m_per[g] == 0 || m_cnt[g] == m_per[g] * 255 - 1) begin
            m_cnt[g] = 0; m_per[g] = c_per[g]; m_duty[g] = c_duty[g];
          end else begin
            m_cnt[g] = m_cnt[g] + 1;
          end
        end
      end
      if (wr_en) begin
        int a;
        a = int'(wr_addr);
        if (a < 4) begin
          c_duty[2*a]   = int'(wr_data[7:0]);
          c_duty[2*a+1] = int'(wr_data[23:16]);
        end else if (a < 6) begin
          for (int j = 0; j < 4; j++) c_per[4*(a-4)+j] = int'(wr_data[8*j +: 8]);
        end else if (a < 8) begin
          for (int j = 0; j < 8; j++) c_map[8*(a-6)+j] = int'(wr_data[4*j +: 4]);
        end else if (a < 11) begin
          for (int j = 0; j < 8; j++)
            if (16 + 8*(a-8) + j < NP) c_map[16 + 8*(a-8) + j] = int'(wr_data[4*j +: 4]);
        end
      end
    end
  end

  function automatic logic [32:0] model_pins();
    logic [32:0] v;
    for (int p = 0; p < NP; p++) begin
      int g;
      bit w;
      g = c_map[p] % 8;
      w = (m_per[g] != 0) && (m_cnt[g] < m_duty[g] * m_per[g]);
      v[p] = (c_map[p] >= 8) && w;
    end
    return v;
  endfunction

  always @(negedge clk) begin
    if (!done) begin
      logic [32:0] e;
      e = model_pins();
      nchk++;
      if (allp !== e) begin
        nerr++;
        $display("FAIL R3/R6 cycle model: actual=%h expected=%h at %0t", allp, e, $time);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic count_high(input int p, input int n, output int hi);
    hi = 0;
    repeat (n) begin
      @(negedge clk);
      hi += int'(allp[p]);
    end
  endtask

  task automatic wait_rise(input int p);
    logic prev;
    prev = allp[p];
    forever begin
      @(negedge clk);
      if (allp[p] && !prev) break;
      prev = allp[p];
    end
  endtask

  // ---------------- stimulus ----------------
  initial begin
    int hi, n;
    logic prev;
    repeat (3) @(negedge clk);
    check("R1 pins low in reset", int'(allp), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 pins low after reset", int'(allp), 0);

    // R7: gen0 duty 128, gen1 duty 255 (low byte 0x55 ignored)
    wr(4'd0, 32'h55FF_0080);
    // gen2 duty 0, gen3 duty 64, low bytes 0xAA/0xCC ignored
    wr(4'd1, 32'hCC40_AA00);
    // gen4 duty 200, low byte 0x77 ignored
    wr(4'd2, 32'h0000_77C8);
    // R8: periods gen0=2, gen1..3=1; gen4=1 in second word
    wr(4'd4, 32'h0101_0102);
    wr(4'd5, 32'h0000_0001);
    // R9: pin0->g0, pin1->g1, pin2->g2, pin3 disabled (g1), pin4->g3, pin5->g0, pin6->g4
    wr(4'd6, 32'h0C8B_1A98);
    wr(4'd8, 32'h0000_000B);   // serial pin 0 (pin16) -> g3
    wr(4'd10, 32'h0000_0009);  // serial pin 16 (pin32) -> g1
    repeat (1100) @(negedge clk);

    count_high(0, 2040, hi);
    check("R3 duty 128 period 2 high clocks", hi, 1024);
    count_high(5, 2040, hi);
    check("R10 shared generator pin5", hi, 1024);
    count_high(1, 510, hi);
    check("R4 duty 255 always high", hi, 510);
    count_high(2, 510, hi);
    check("R4 duty 0 always low", hi, 0);
    count_high(3, 510, hi);
    check("R10 disabled pin low", hi, 0);
    count_high(4, 510, hi);
    check("R7 low field ignored, duty 64", hi, 128);
    count_high(6, 510, hi);
    check("R8 generator 4 in second period word", hi, 400);
    count_high(32, 510, hi);
    check("R9 last serial pin follows gen1", hi, 510);
    count_high(16, 510, hi);
    check("R9 first serial pin follows gen3", hi, 128);

    // R2: period length in clocks
    wait_rise(4);
    n = 0; prev = 1'b1;
    forever begin
      @(negedge clk);
      n++;
      if (allp[4] && !prev) break;
      prev = allp[4];
    end
    check("R2 period length clocks", n, 510);

    // R6: change gen1 to duty 0 just after its period starts
    wait_rise(4);
    wr(4'd0, 32'h0000_0080);
    repeat (8) @(negedge clk);
    check("R6 running period keeps old duty", int'(allp[1]), 1);
    repeat (520) @(negedge clk);
    check("R6 new duty after boundary", int'(allp[1]), 0);

    // R5: stop gen3, then restart
    wr(4'd4, 32'h0001_0102);
    repeat (600) @(negedge clk);
    count_high(4, 510, hi);
    check("R5 stopped generator low", hi, 0);
    count_high(16, 510, hi);
    check("R5 stopped generator low on serial pin", hi, 0);
    wr(4'd4, 32'h0101_0102);
    repeat (4) @(negedge clk);
    check("R5 prompt restart high", int'(allp[4]), 1);
    repeat (20) @(negedge clk);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

endmodule